// File: doc/BRIEF.md
# Parallel Port Receive Handshake

This block is the receiving end of a byte-wide printer port on the host link. When the host pulls the strobe low, the block takes a byte from the eight data lines and raises BUSY at once. It then offers the byte to a downstream receive buffer over a valid/ready pair. The buffer has a bounded time to accept the byte. When the buffer accepts it, or when that time runs out, the block drives a timed active-low acknowledge pulse. BUSY falls on the same edge that the acknowledge pulse ends, so the host sees BUSY drop only with the end of the acknowledge.

The strobe and the init line come in from the cable asynchronously. Each goes through a two-flop synchronizer, and the strobe falling edge is detected after that. A strobe that falls while a transfer is still in progress does not capture a byte and sets a sticky overrun flag. A configuration bit decides whether the init line returns the handshake to idle. Three printer status lines (paper empty, selected, fault) are registered before they leave the block.

Top module: `pp_rx_handshake`

## Requirements
- R1: After reset, busy is 0, ack_n is 1, rx_valid is 0 and overrun is 0.
- R2: When strobe_n goes low while the block is idle, busy is still 0 after the first rising clock edge and is 1 after the second rising clock edge, because strobe_n passes through two synchronizer flops.
- R3: On the third rising clock edge after strobe_n falls, rx_valid goes to 1 and rx_data holds the byte that was on data_in. Both stay unchanged until the byte is accepted or the store timeout expires.
- R4: The byte is accepted on an edge where rx_valid and rx_ready are both 1. On that edge rx_valid drops and ack_n goes low. ack_n then stays low for exactly L clock cycles, where L is cfg_ack_len.
- R5: busy stays 1 for the whole time ack_n is low, and falls on the same edge that ack_n returns to 1.
- R6: If rx_ready stays 0, rx_valid stays high for exactly STORE_TIMEOUT cycles. rx_valid is then withdrawn and the acknowledge pulse is issued anyway.
- R7: A strobe falling edge that arrives while busy is 1 captures nothing. rx_data keeps its byte, no second rx_valid follows, and overrun is set and stays 1.
- R8: When init_en is 1, holding init_n low (after two synchronizer flops) returns the block to idle. busy goes to 0, ack_n to 1, rx_valid to 0 and overrun to 0.
- R9: When init_en is 0, init_n has no effect on a transfer in progress.
- R10: pe, sel and fault_n show paper_out, online and the inverse of error_in one clock cycle later.
- R11: A cfg_ack_len of 0 selects the default acknowledge width of ACK_CYCLES cycles (500, about 5 us at 100 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_n | input | 1 | Host data strobe, active low, asynchronous |
| data_in | input | DATA_W | Host data lines |
| init_n | input | 1 | Host init request, active low, asynchronous |
| init_en | input | 1 | 1 lets init_n reset the handshake |
| cfg_ack_len | input | LEN_W | Acknowledge width in cycles, 0 selects ACK_CYCLES |
| rx_ready | input | 1 | Receive buffer can take the byte |
| paper_out | input | 1 | Paper empty condition |
| online | input | 1 | Printer selected condition |
| error_in | input | 1 | Printer fault condition |
| busy | output | 1 | Busy to the host, active high |
| ack_n | output | 1 | Acknowledge to the host, active low |
| rx_valid | output | 1 | Byte offered to the receive buffer |
| rx_data | output | DATA_W | Captured byte |
| overrun | output | 1 | Sticky: a strobe came while busy |
| pe | output | 1 | Registered paper empty |
| sel | output | 1 | Registered select |
| fault_n | output | 1 | Registered fault, active low |

## Verification
Each result has a fixed due cycle: busy rises two rising edges after a strobe fall, rx_valid and rx_data follow one edge later, and ack_n falls on the edge that accepts the byte. The bench drives every input on a falling clock edge and samples on falling edges. It can therefore count exactly how many edges have passed and check a value in the very cycle it is due, which also shows that the value was not there a cycle early. Acknowledge width and store timeout are measured by counting the falling-edge samples during which ack_n or rx_valid stays active. Those counts are compared with cfg_ack_len, the default width and STORE_TIMEOUT.

// File: rtl/pp_rx_pkg.sv
// Shared types for the parallel port receive handshake.
package pp_rx_pkg;
    // Handshake states: waiting for a strobe, offering a byte, acknowledging
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_STORE = 2'd1,
        HS_ACK   = 2'd2
    } hs_state_t;
endpackage

// File: rtl/pp_sync.sv
// Two-flop synchronizer for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent; no multi-bit coherence is provided.
module pp_sync #(
    parameter int          WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta;
        logic stab;
        // Two register stages per bit to settle metastability
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta <= RST_VAL[i];
                stab <= RST_VAL[i];
            end else begin
                meta <= d[i];
                stab <= meta;
            end
        end
        assign q[i] = stab;
    end
endmodule

// File: rtl/pp_hs_ctrl.sv
// Handshake controller: detects the falling edge of the synchronized strobe,
// captures the byte, offers it downstream with a bounded store window, then
// drives a counted acknowledge pulse. Assumes strb_s is already synchronized
// and that data_in is held stable around the strobe for several cycles.
module pp_hs_ctrl
    import pp_rx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int LEN_W         = 10,
    parameter int CNT_W         = 11,
    parameter int ACK_CYCLES    = 500,
    parameter int STORE_TIMEOUT = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_s,
    input  logic              init_act,
    input  logic [DATA_W-1:0] data_in,
    input  logic [LEN_W-1:0]  cfg_ack_len,
    input  logic              rx_ready,
    output logic              busy,
    output logic              ack_n,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              overrun
);
    localparam logic [CNT_W-1:0] STORE_LAST = CNT_W'(STORE_TIMEOUT - 1);

    hs_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] data_q;
    logic              strb_d;
    logic              ovr_q;
    logic              fall;
    logic              take;
    logic [LEN_W-1:0]  ack_len;
    logic [CNT_W-1:0]  ack_load;

    // Delayed copy of the synchronized strobe for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) strb_d <= 1'b1;
        else        strb_d <= strb_s;
    end

    // Edge detect, acceptance of a new byte and acknowledge length selection
    always_comb begin
        fall     = strb_d & ~strb_s;
        take     = fall & (state == HS_IDLE) & ~init_act;
        ack_len  = (cfg_ack_len == '0) ? LEN_W'(ACK_CYCLES) : cfg_ack_len;
        ack_load = CNT_W'(ack_len) - CNT_W'(1);
    end

    // Handshake sequencing, byte capture, store window and acknowledge timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= HS_IDLE;
            cnt    <= '0;
            data_q <= '0;
            ovr_q  <= 1'b0;
        end else if (init_act) begin
            state <= HS_IDLE;
            cnt   <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (fall && state != HS_IDLE) ovr_q <= 1'b1;
            case (state)
                HS_IDLE: begin
                    if (take) begin
                        state  <= HS_STORE;
                        cnt    <= '0;
                        data_q <= data_in;
                    end
                end
                HS_STORE: begin
                    if (rx_ready || cnt == STORE_LAST) begin
                        state <= HS_ACK;
                        cnt   <= ack_load;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                HS_ACK: begin
                    if (cnt == '0) state <= HS_IDLE;
                    else           cnt   <= cnt - CNT_W'(1);
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    // Port-facing decode of the state
    always_comb begin
        busy     = (state != HS_IDLE) | take;
        ack_n    = (state != HS_ACK);
        rx_valid = (state == HS_STORE);
        rx_data  = data_q;
        overrun  = ovr_q;
    end
endmodule

// File: rtl/pp_rx_handshake.sv
// Top of the parallel port receive side: synchronizes strobe and init,
// runs the handshake controller and registers the printer status lines.
// Assumes a single clock domain downstream; host lines are asynchronous.
module pp_rx_handshake
    import pp_rx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int LEN_W         = 10,
    parameter int ACK_CYCLES    = 500,
    parameter int STORE_TIMEOUT = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              init_n,
    input  logic              init_en,
    input  logic [LEN_W-1:0]  cfg_ack_len,
    input  logic              rx_ready,
    input  logic              paper_out,
    input  logic              online,
    input  logic              error_in,
    output logic              busy,
    output logic              ack_n,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              overrun,
    output logic              pe,
    output logic              sel,
    output logic              fault_n
);
    localparam int TO_W  = $clog2(STORE_TIMEOUT + 1);
    localparam int CNT_W = (TO_W > LEN_W) ? TO_W : LEN_W;

    logic [1:0] sync_q;
    logic       init_act;

    pp_sync #(
        .WIDTH   (2),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({init_n, strobe_n}),
        .q     (sync_q)
    );

    // Init request is honoured only when enabled by configuration
    assign init_act = init_en & ~sync_q[1];

    pp_hs_ctrl #(
        .DATA_W        (DATA_W),
        .LEN_W         (LEN_W),
        .CNT_W         (CNT_W),
        .ACK_CYCLES    (ACK_CYCLES),
        .STORE_TIMEOUT (STORE_TIMEOUT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .strb_s      (sync_q[0]),
        .init_act    (init_act),
        .data_in     (data_in),
        .cfg_ack_len (cfg_ack_len),
        .rx_ready    (rx_ready),
        .busy        (busy),
        .ack_n       (ack_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .overrun     (overrun)
    );

    // Register the status lines driven back to the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe      <= 1'b0;
            sel     <= 1'b0;
            fault_n <= 1'b1;
        end else begin
            pe      <= paper_out;
            sel     <= online;
            fault_n <= ~error_in;
        end
    end
endmodule

// File: rtl/pp_rx_checks.sv
// Property checker for pp_rx_handshake, attached with bind below.
// Observes ports plus the qualified init request of the top.
module pp_rx_checks #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_act,
    input logic              busy,
    input logic              ack_n,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              overrun,
    input logic              paper_out,
    input logic              pe
);
    p_valid_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);

    p_data_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(rx_valid)) |-> $stable(rx_data));

    p_ack_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> busy);

    p_busy_drop_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !init_act && !$past(init_act)) |-> $rose(ack_n));

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !init_act) |=> overrun);

    p_pe_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pe == $past(paper_out)));
endmodule

bind pp_rx_handshake pp_rx_checks #(.DATA_W(DATA_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_act  (init_act),
    .busy      (busy),
    .ack_n     (ack_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .overrun   (overrun),
    .paper_out (paper_out),
    .pe        (pe)
);

// File: tb/tb_pp_rx_handshake.sv
module tb_pp_rx_handshake;
    localparam int DW    = 8;
    localparam int LW    = 10;
    localparam int DEF_L = 12;
    localparam int TO    = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_n = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic          init_n = 1'b1;
    logic          init_en = 1'b0;
    logic [LW-1:0] cfg_ack_len = '0;
    logic          rx_ready = 1'b0;
    logic          paper_out = 1'b0;
    logic          online = 1'b0;
    logic          error_in = 1'b0;
    logic          busy, ack_n, rx_valid, overrun, pe, sel, fault_n;
    logic [DW-1:0] rx_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pp_rx_handshake #(
        .DATA_W(DW), .LEN_W(LW), .ACK_CYCLES(DEF_L), .STORE_TIMEOUT(TO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .data_in(data_in),
        .init_n(init_n), .init_en(init_en), .cfg_ack_len(cfg_ack_len),
        .rx_ready(rx_ready), .paper_out(paper_out), .online(online),
        .error_in(error_in), .busy(busy), .ack_n(ack_n), .rx_valid(rx_valid),
        .rx_data(rx_data), .overrun(overrun), .pe(pe), .sel(sel), .fault_n(fault_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Strobe low at a falling edge, return at the sample where rx_valid is due
    task automatic send_byte(input logic [DW-1:0] b);
        strobe_n = 1'b0;
        data_in  = b;
        step(3);
    endtask

    // Accept the offered byte and wait for the acknowledge to finish
    task automatic accept_and_finish();
        rx_ready = 1'b1;
        step(1);
        rx_ready = 1'b0;
        for (int i = 0; i < 2000 && !ack_n; i++) step(1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 busy", busy, 0);
        check("R1 ack_n", ack_n, 1);
        check("R1 rx_valid", rx_valid, 0);
        check("R1 overrun", overrun, 0);
    endtask

    // Full transfer with measured busy latency and acknowledge width
    task automatic t_transfer(input logic [DW-1:0] b, input int cfg, input int exp_len, input string req);
        int n;
        int busy_low;
        cfg_ack_len = LW'(cfg);
        strobe_n = 1'b0;
        data_in  = b;
        step(1);
        check("R2 busy after one edge", busy, 0);
        step(1);
        check("R2 busy after two edges", busy, 1);
        check("R3 rx_valid not early", rx_valid, 0);
        step(1);
        check("R3 rx_valid", rx_valid, 1);
        check("R3 rx_data", rx_data, b);
        strobe_n = 1'b1;
        data_in  = ~b;
        step(2);
        check("R3 rx_valid held", rx_valid, 1);
        check("R3 rx_data held", rx_data, b);
        rx_ready = 1'b1;
        step(1);
        rx_ready = 1'b0;
        check("R4 ack_n low on accept", ack_n, 0);
        check("R4 rx_valid dropped", rx_valid, 0);
        n = 0;
        busy_low = 0;
        while (!ack_n && n < 2000) begin
            if (!busy) busy_low++;
            n++;
            step(1);
        end
        check(req, n, exp_len);
        check("R5 busy during ack", busy_low, 0);
        check("R5 busy drops with ack", busy, 0);
    endtask

    task automatic t_timeout();
        int n;
        cfg_ack_len = LW'(4);
        send_byte(8'h5A);
        strobe_n = 1'b1;
        n = 0;
        while (rx_valid && n < 2000) begin
            n++;
            step(1);
        end
        check("R6 store window", n, TO);
        check("R6 ack after timeout", ack_n, 0);
        for (int i = 0; i < 100 && !ack_n; i++) step(1);
        check("R6 busy released", busy, 0);
    endtask

    task automatic t_overrun();
        send_byte(8'hA5);
        strobe_n = 1'b1;
        step(2);
        strobe_n = 1'b0;
        data_in  = 8'h3C;
        step(4);
        check("R7 data kept", rx_data, 8'hA5);
        check("R7 overrun set", overrun, 1);
        accept_and_finish();
        step(4);
        check("R7 no second byte", rx_valid, 0);
        check("R7 idle", busy, 0);
        check("R7 overrun sticky", overrun, 1);
        strobe_n = 1'b1;
        step(3);
    endtask

    task automatic t_init_on();
        init_en = 1'b1;
        send_byte(8'h77);
        check("R8 precondition", overrun, 1);
        init_n = 1'b0;
        step(4);
        check("R8 busy", busy, 0);
        check("R8 ack_n", ack_n, 1);
        check("R8 rx_valid", rx_valid, 0);
        check("R8 overrun", overrun, 0);
        init_n = 1'b1;
        strobe_n = 1'b1;
        step(3);
        check("R8 stays idle", busy, 0);
    endtask

    task automatic t_init_off();
        init_en = 1'b0;
        send_byte(8'h81);
        init_n = 1'b0;
        step(5);
        check("R9 rx_valid", rx_valid, 1);
        check("R9 busy", busy, 1);
        check("R9 rx_data", rx_data, 8'h81);
        init_n = 1'b1;
        strobe_n = 1'b1;
        accept_and_finish();
    endtask

    task automatic t_status();
        paper_out = 1'b1;
        online    = 1'b0;
        error_in  = 1'b1;
        check("R10 pe before edge", pe, 0);
        step(1);
        check("R10 pe", pe, 1);
        check("R10 sel", sel, 0);
        check("R10 fault_n", fault_n, 0);
        paper_out = 1'b0;
        online    = 1'b1;
        error_in  = 1'b0;
        step(1);
        check("R10 pe clear", pe, 0);
        check("R10 sel set", sel, 1);
        check("R10 fault_n clear", fault_n, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        step(1);
        t_reset();
        t_transfer(8'hC3, 3, 3, "R4 ack width programmed");
        step(2);
        t_transfer(8'h1E, 0, DEF_L, "R11 default ack width");
        step(2);
        t_transfer(8'hFF, 1, 1, "R4 ack width one");
        step(2);
        t_timeout();
        step(2);
        t_overrun();
        t_init_on();
        t_init_off();
        t_status();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule